// File: doc/BRIEF.md
# Sixteen-bit Opcode-Selected Arithmetic-Logic Unit

This block is the compute stage of a small 16-bit register machine. It takes a 4-bit operation code and two 16-bit operands and returns a 16-bit result in the same evaluation. It has no clock, no reset and no internal state. The instruction decoder passes the opcode field and the two source register values straight in, and writes the result to the destination register when the block reports a compute operation.

The low nine opcodes select bitwise logic, addition, multiplication, unsigned division and shifts by a register-held amount. The upper seven opcodes belong to memory, move and branch instructions. For those the unit drives a zero result and deasserts its valid flag, so the caller can route the instruction elsewhere. A separate flag marks division by zero.

Top module: `alu16_core`

## Requirements
- R1: Opcode 0000 gives A AND B, 0001 gives A OR B, and 0010 gives A XOR B, where A is `operand_a` and B is `operand_b`.
- R2: Opcode 0011 gives the bitwise inverse of A. The value of B has no effect on the result.
- R3: Opcode 0100 gives A + B, keeping only the low 16 bits.
- R4: Opcode 0101 gives A * B, keeping only the low 16 bits of the product.
- R5: Opcode 0110 with B nonzero gives the unsigned quotient A / B, truncated toward zero, and leaves `div_by_zero` at 0.
- R6: Opcode 0110 with B equal to zero gives 16'hFFFF and raises `div_by_zero`. For every other opcode, `div_by_zero` is 0.
- R7: Opcode 0111 shifts A left by the unsigned amount in B. Any amount of 16 or more gives zero.
- R8: Opcode 1000 shifts A right logically, filling with zeros, by the unsigned amount in B. Any amount of 16 or more gives zero.
- R9: Opcodes 0000 to 1000 assert `alu_valid`. Opcodes 1001 to 1111 deassert it and drive `result` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select, taken from the instruction's top nibble |
| operand_a | input | 16 | First source value, the left-hand operand |
| operand_b | input | 16 | Second source value, the right-hand operand or shift amount |
| result | output | 16 | Operation outcome, zero for non-compute opcodes |
| alu_valid | output | 1 | High when op_code is one of the nine compute operations |
| div_by_zero | output | 1 | High when a divide has a zero divisor |

## Verification
The corner cases that random operands almost never hit are a zero divisor, and shift amounts exactly at, just below and far above the 16-bit boundary. Random B values fall almost entirely above 16. The stimulus therefore starts with directed vectors for each of these. It then runs a random phase where every fourth vector draws B from the range 0 to 17, so that divide-by-zero and boundary shifts come up again and again, mixed with every opcode. The wrap-around cases for add and multiply (all-ones operands) are also directed, because random operands reach them only by chance.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    localparam int DATA_W_DEF = 16;
    localparam int OP_W       = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'h0,
        OP_OR  = 4'h1,
        OP_XOR = 4'h2,
        OP_NOT = 4'h3,
        OP_ADD = 4'h4,
        OP_MUL = 4'h5,
        OP_DIV = 4'h6,
        OP_SHL = 4'h7,
        OP_SHR = 4'h8
    } alu_op_e;

    typedef enum logic [1:0] {
        UNIT_NONE  = 2'd0,
        UNIT_LOGIC = 2'd1,
        UNIT_ARITH = 2'd2,
        UNIT_SHIFT = 2'd3
    } alu_unit_e;

    typedef struct packed {
        logic      compute;
        alu_unit_e unit;
    } alu_route_t;

    function automatic alu_route_t route_of(input logic [OP_W-1:0] code);
        alu_route_t r;
        r.compute = (code <= OP_SHR);
        unique case (code)
            OP_AND, OP_OR, OP_XOR, OP_NOT: r.unit = UNIT_LOGIC;
            OP_ADD, OP_MUL, OP_DIV:        r.unit = UNIT_ARITH;
            OP_SHL, OP_SHR:                r.unit = UNIT_SHIFT;
            default:                       r.unit = UNIT_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu16_bitwise.sv
module alu16_bitwise
    import alu16_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOT:  y = ~a;
            default: y = '0;
        endcase
    end

    // The inverse must not depend on the second operand
    always_comb begin
        if (op == OP_NOT) begin
            AST_NOT_IGNORES_B: assert ((y ^ a) == {DATA_W{1'b1}})
                else $error("NOT result is not the inverse of A"); // R2
        end
    end

endmodule

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y,
    output logic              dbz
);

    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] prod;
    logic [DATA_W-1:0] quot;
    logic              b_zero;

    assign b_zero = (b == '0);
    assign sum    = a + b;
    assign prod   = a * b;
    assign quot   = b_zero ? {DATA_W{1'b1}} : (a / b);

    always_comb begin
        dbz = 1'b0;
        unique case (op)
            OP_ADD: y = sum;
            OP_MUL: y = prod;
            OP_DIV: begin
                y   = quot;
                dbz = b_zero;
            end
            default: y = '0;
        endcase
    end

    logic [DATA_W-1:0] add_back;
    assign add_back = y - b;

    always_comb begin
        if (op == OP_ADD) begin
            AST_ADD_WRAPS: assert (add_back == a)
                else $error("ADD result minus B differs from A"); // R3
        end
        if (op == OP_DIV && !b_zero) begin
            AST_DIV_BOUND: assert (y <= a && dbz == 1'b0)
                else $error("quotient exceeds dividend"); // R5
        end
    end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
    import alu16_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    localparam int AMT_W = $clog2(DATA_W);

    logic              too_far;
    logic [AMT_W-1:0]  amt;
    logic [DATA_W-1:0] left_v;
    logic [DATA_W-1:0] right_v;

    generate
        if (DATA_W == (1 << AMT_W)) begin : g_pow2
            assign too_far = |(b >> AMT_W);
        end else begin : g_npow2
            assign too_far = (b >= DATA_W[DATA_W-1:0]);
        end
    endgenerate

    assign amt     = b[AMT_W-1:0];
    assign left_v  = a << amt;
    assign right_v = a >> amt;

    always_comb begin
        unique case (op)
            OP_SHL:  y = too_far ? '0 : left_v;
            OP_SHR:  y = too_far ? '0 : right_v;
            default: y = '0;
        endcase
    end

    always_comb begin
        if (op == OP_SHL && b >= DATA_W) begin
            AST_SHL_RANGE: assert (y == '0)
                else $error("left shift past width not zero"); // R7
        end
        if (op == OP_SHR && b >= DATA_W) begin
            AST_SHR_RANGE: assert (y == '0)
                else $error("right shift past width not zero"); // R8
        end
    end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] operand_a,
    input  logic [DATA_W-1:0] operand_b,
    output logic [DATA_W-1:0] result,
    output logic              alu_valid,
    output logic              div_by_zero
);

    alu_route_t        route;
    alu_op_e           op;
    logic [DATA_W-1:0] y_logic;
    logic [DATA_W-1:0] y_arith;
    logic [DATA_W-1:0] y_shift;
    logic              arith_dbz;

    assign route = route_of(op_code);
    assign op    = alu_op_e'(op_code);

    alu16_bitwise #(.DATA_W(DATA_W)) u_bitwise (
        .op (op),
        .a  (operand_a),
        .b  (operand_b),
        .y  (y_logic)
    );

    alu16_arith #(.DATA_W(DATA_W)) u_arith (
        .op  (op),
        .a   (operand_a),
        .b   (operand_b),
        .y   (y_arith),
        .dbz (arith_dbz)
    );

    alu16_shift #(.DATA_W(DATA_W)) u_shift (
        .op (op),
        .a  (operand_a),
        .b  (operand_b),
        .y  (y_shift)
    );

    always_comb begin
        unique case (route.unit)
            UNIT_LOGIC: result = y_logic;
            UNIT_ARITH: result = y_arith;
            UNIT_SHIFT: result = y_shift;
            default:    result = '0;
        endcase
    end

    assign alu_valid   = route.compute;
    assign div_by_zero = route.compute & arith_dbz;

    always_comb begin
        if (!alu_valid) begin
            AST_IDLE_ZERO: assert (result == '0 && !div_by_zero)
                else $error("non-compute opcode leaked a value"); // R9
        end
        if (div_by_zero) begin
            AST_DBZ_SAT: assert (alu_valid && result == {DATA_W{1'b1}} && operand_b == '0)
                else $error("divide-by-zero result malformed"); // R6
        end
    end

endmodule

// File: tb/alu16_core_bench.sv
module alu16_core_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_code;
    logic [15:0] operand_a;
    logic [15:0] operand_b;
    logic [15:0] result;
    logic        alu_valid;
    logic        div_by_zero;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu16_core u_alu16_core (
        .op_code     (op_code),
        .operand_a   (operand_a),
        .operand_b   (operand_b),
        .result      (result),
        .alu_valid   (alu_valid),
        .div_by_zero (div_by_zero)
    );

    function automatic string req_tag(input int op, input int b);
        case (op)
            0, 1, 2: return "R1";
            3:       return "R2";
            4:       return "R3";
            5:       return "R4";
            6:       return (b == 0) ? "R6" : "R5";
            7:       return "R7";
            8:       return "R8";
            default: return "R9";
        endcase
    endfunction

    // Behavioural model from the requirement list, on wide integers
    task automatic model(input int op, input int a, input int b,
                         output int ey, output bit ev, output bit ed);
        longint la = a;
        longint lb = b;
        longint r  = 0;
        ev = (op <= 8);
        ed = 1'b0;
        case (op)
            0: r = la & lb;
            1: r = la | lb;
            2: r = la ^ lb;
            3: r = 65535 - la;
            4: r = la + lb;
            5: r = la * lb;
            6: if (lb == 0) begin r = 65535; ed = 1'b1; end else r = la / lb;
            7: r = (lb >= 16) ? 0 : (la << lb);
            8: r = (lb >= 16) ? 0 : (la >> lb);
            default: r = 0;
        endcase
        ey = int'(r % 65536);
    endtask

    task automatic apply(input int op, input int a, input int b);
        int ey; bit ev; bit ed;
        @(posedge clk);
        op_code   = op[3:0];
        operand_a = a[15:0];
        operand_b = b[15:0];
        @(negedge clk);
        model(op, a, b, ey, ev, ed);
        checks++;
        if (int'(result) != ey || alu_valid != ev || div_by_zero != ed) begin
            fails++;
            $display("FAIL %s op=%0d a=%h b=%h: got y=%h v=%0b dz=%0b, expected y=%h v=%0b dz=%0b",
                     req_tag(op, b), op, a[15:0], b[15:0], result, alu_valid, div_by_zero,
                     ey[15:0], ev, ed);
        end
    endtask

    initial begin : watchdog
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1;
        op_code = 4'h0; operand_a = '0; operand_b = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Reset state: idle inputs give AND of zeros, valid, no div flag (R1, R9)
        apply(0, 0, 0);

        // R1 bitwise
        apply(0, 16'hF0F0, 16'hFF00);
        apply(1, 16'hF0F0, 16'h0F0F);
        apply(2, 16'hAAAA, 16'hFFFF);
        // R2 NOT ignores B
        apply(3, 16'h1234, 16'h0000);
        apply(3, 16'h1234, 16'hFFFF);
        // R3 add wrap
        apply(4, 16'hFFFF, 16'h0001);
        apply(4, 16'h7FFF, 16'h7FFF);
        // R4 multiply truncation
        apply(5, 16'h1234, 16'h0010);
        apply(5, 16'hFFFF, 16'hFFFF);
        // R5 divide
        apply(6, 100, 7);
        apply(6, 16'hFFFF, 1);
        apply(6, 3, 16'hFFFF);
        // R6 divide by zero
        apply(6, 5, 0);
        apply(6, 0, 0);
        // R7 left shift bounds
        apply(7, 16'h0001, 0);
        apply(7, 16'h0001, 15);
        apply(7, 16'hFFFF, 16);
        apply(7, 16'hFFFF, 16'hFFFF);
        // R8 right shift bounds, logical fill
        apply(8, 16'h8000, 15);
        apply(8, 16'h8000, 1);
        apply(8, 16'hFFFF, 16);
        apply(8, 16'hFFFF, 16'h0100);
        // R9 non-compute opcodes, even with a zero divisor
        for (int op = 9; op < 16; op++) apply(op, 16'hBEEF, 0);

        // Mixed random phase, small B on every fourth vector
        for (int i = 0; i < 3000; i++) begin
            int op = int'($urandom_range(0, 15));
            int a  = int'($urandom_range(0, 65535));
            int b  = (i % 4 == 0) ? int'($urandom_range(0, 17)) : int'($urandom_range(0, 65535));
            apply(op, a, b);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule